// File: doc/BRIEF.md
# Differential Clock Output Gating and Power-Down Controller

This block sits between a PLL and the output drivers of a six-pair differential clock buffer that also has one single-ended reference output. Each differential pair runs only when three conditions hold together: power-good is high, the pair's register enable bit is set, and the pair's active-low enable pin is pulled low. Every pair is also held parked until the PLL reports lock. A parked pair drives both legs low. Pairs start and stop only at phase boundaries, so no leg ever shows a shortened high phase. The pair frequency is half the `clk_pll` rate.

The reference output is a half-rate copy of `clk_ref`. Its driver stays disabled (high impedance) from reset until power-good is first seen high. After that point it is always driven: it toggles while power-good is high and sits low while power-good is low. The same first power-good event samples an address strap and fixes the 7-bit serial-bus address until the next reset. A spread selector is re-encoded into the 2-bit code the PLL expects. The enable pins, register bits, lock and power-good are asynchronous and pass through two-flop synchronizers in each clock domain before use. Reset is synchronous and active high in both domains.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: A pair whose synchronized conditions all hold (power-good 1, lock 1, register bit 1, pin 0) runs. Its true leg toggles on every `clk_pll` edge and its complement leg is always the inverse of the true leg.
- R2: While power-good is low, every pair is parked, with both legs low.
- R3: A pair whose register bit is 0, or whose pin is 1, is parked with both legs low. Other pairs are unaffected.
- R4: While the PLL lock input is low, every pair is parked with both legs low.
- R5: The true leg is never high for two consecutive `clk_pll` cycles. A complement high phase is always followed by a true high phase. The two legs are never high together.
- R6: A running pair stops only after a true high phase. Once the pair's enable has dropped, the cycle after that phase has both legs low.
- R7: `ref_oe` is 0 from reset until synchronized power-good is first high. It then stays 1 until the next reset.
- R8: While `ref_oe` is 1, `ref_out` toggles on every `clk_ref` cycle if power-good is high, and is held at 0 if power-good is low.
- R9: `bus_addr` resets to 7'b1101000. At the first power-good it takes 7'b1101000 if the strap is 0, or 7'b1101010 if the strap is 1.
- R10: Later power-good cycles do not resample the strap; `bus_addr` only changes again after reset.
- R11: `pll_ss_code` maps `ss_sel` as follows: 00 (no spread) gives 00, 01 (-0.25%) gives 01, 10 (-0.5%) gives 10, and the unused 11 gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL clock, twice the pair output rate |
| clk_ref | input | 1 | Running reference clock, twice the reference output rate |
| rst | input | 1 | Synchronous active-high reset for both domains |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| pwr_good | input | 1 | Power-good (high) / power-down (low), asynchronous |
| oe_n | input | 6 | Per-pair enable pins, active low |
| reg_oe | input | 6 | Per-pair register enable bits, 1 = enabled |
| addr_strap | input | 1 | Address-select strap |
| ss_sel | input | 2 | Spread selection |
| dif_t | output | 6 | True legs of the pairs |
| dif_c | output | 6 | Complement legs of the pairs |
| ref_out | output | 1 | Reference output data |
| ref_oe | output | 1 | Reference driver enable, 0 = high impedance |
| bus_addr | output | 7 | Latched 7-bit serial-bus address |
| pll_ss_code | output | 2 | Encoded spread code for the PLL |

## Verification
Two events can land in the same cycle: a power-down and the release of a pair's enable pin. Both events can also arrive while the pair is partway through a phase. The bench drops power-good and raises an enable pin on one edge, with the pair running, and then watches the legs on every `clk_pll` cycle. It flags any overlapping high, any true phase stretched to two cycles, and any complement phase that is not followed by a true phase, and it requires both legs low at the end. A second coincidence is the first power-good arriving together with a strap value. The bench judges this case by the latched address and by the reference driver turning on, and then changes the strap across a later power cycle to confirm the address stays fixed.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int NUM_PAIRS   = 6;
    localparam int ADDR_W      = 7;
    localparam int SYNC_DEPTH  = 2;

    localparam logic [ADDR_W-1:0] ADDR_STRAP_LO = 7'b1101000;
    localparam logic [ADDR_W-1:0] ADDR_STRAP_HI = 7'b1101010;

    typedef enum logic [1:0] {
        SPREAD_NONE = 2'b00,
        SPREAD_Q    = 2'b01,
        SPREAD_H    = 2'b10
    } spread_code_e;

    typedef struct packed {
        logic t;
        logic c;
    } dif_pair_t;

    function automatic spread_code_e spread_encode(input logic [1:0] sel);
        case (sel)
            2'b01:   return SPREAD_Q;
            2'b10:   return SPREAD_H;
            default: return SPREAD_NONE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] strap_to_addr(input logic strap);
        return strap ? ADDR_STRAP_HI : ADDR_STRAP_LO;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane
    import clkgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    output dif_pair_t pair
);
    dif_pair_t st;

    // A true high phase is always completed; the complement high phase
    // always hands over to a true phase, so stopping happens only after t.
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.t) begin
            st.t <= 1'b0;
            st.c <= en;
        end else if (st.c || en) begin
            st.t <= 1'b1;
            st.c <= 1'b0;
        end else begin
            st <= '0;
        end
    end

    assign pair = st;

    a_r5_never_both_high: assert property (@(posedge clk) disable iff (rst)
        !(pair.t && pair.c));
    a_r5_true_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pair.t |=> !pair.t);
    a_r5_comp_then_true: assert property (@(posedge clk) disable iff (rst)
        pair.c |=> pair.t);
    a_r6_park_after_true: assert property (@(posedge clk) disable iff (rst)
        (pair.t && !en) |=> (!pair.t && !pair.c));
    a_r1_start_from_park: assert property (@(posedge clk) disable iff (rst)
        (!pair.t && !pair.c && en) |=> pair.t);
endmodule

// File: rtl/clkgate_ref_ctrl.sv
module clkgate_ref_ctrl
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_s,
    input  logic              strap_s,
    output logic              ref_out,
    output logic              ref_oe,
    output logic [ADDR_W-1:0] addr
);
    logic pg_seen;
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_seen <= 1'b0;
            addr    <= ADDR_STRAP_LO;
            ref_q   <= 1'b0;
        end else begin
            if (pg_s && !pg_seen) begin
                pg_seen <= 1'b1;
                addr    <= strap_to_addr(strap_s);
            end
            ref_q <= ref_q ? 1'b0 : pg_s;
        end
    end

    assign ref_out = ref_q;
    assign ref_oe  = pg_seen;

    a_r7_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        ref_oe |=> ref_oe);
    a_r7_oe_on_first_pg: assert property (@(posedge clk) disable iff (rst)
        (pg_s && !ref_oe) |=> ref_oe);
    a_r8_low_when_down: assert property (@(posedge clk) disable iff (rst)
        !pg_s |=> !ref_out);
    a_r9_latch_strap: assert property (@(posedge clk) disable iff (rst)
        (pg_s && !ref_oe) |=> (addr == strap_to_addr($past(strap_s))));
    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        ref_oe |=> $stable(addr));
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N     = NUM_PAIRS,
    parameter int SYNCS = SYNC_DEPTH
) (
    input  logic              clk_pll,
    input  logic              clk_ref,
    input  logic              rst,
    input  logic              pll_locked,
    input  logic              pwr_good,
    input  logic [N-1:0]      oe_n,
    input  logic [N-1:0]      reg_oe,
    input  logic              addr_strap,
    input  logic [1:0]        ss_sel,
    output logic [N-1:0]      dif_t,
    output logic [N-1:0]      dif_c,
    output logic              ref_out,
    output logic              ref_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        pll_ss_code
);
    localparam int PLL_SYNC_W = 2 + 2 * N;

    logic [PLL_SYNC_W-1:0] pll_raw, pll_s;
    logic                  pg_p, lock_p;
    logic [N-1:0]          reg_p, oen_p, lane_en;
    logic [1:0]            ref_s;

    assign pll_raw = {pwr_good, pll_locked, reg_oe, oe_n};

    clkgate_sync #(.W(PLL_SYNC_W), .STAGES(SYNCS)) u_sync_pll (
        .clk(clk_pll), .rst(rst), .d(pll_raw), .q(pll_s)
    );

    assign {pg_p, lock_p, reg_p, oen_p} = pll_s;

    clkgate_sync #(.W(2), .STAGES(SYNCS)) u_sync_ref (
        .clk(clk_ref), .rst(rst), .d({pwr_good, addr_strap}), .q(ref_s)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            dif_pair_t p;
            assign lane_en[i] = pg_p && lock_p && reg_p[i] && !oen_p[i];
            clkgate_lane u_lane (
                .clk(clk_pll), .rst(rst), .en(lane_en[i]), .pair(p)
            );
            assign dif_t[i] = p.t;
            assign dif_c[i] = p.c;

            a_r2_park_on_power_down: assert property (@(posedge clk_pll) disable iff (rst)
                (!pg_p && !dif_t[i] && !dif_c[i]) |=> (!dif_t[i] && !dif_c[i]));
            a_r4_park_until_lock: assert property (@(posedge clk_pll) disable iff (rst)
                (!lock_p && !dif_t[i] && !dif_c[i]) |=> (!dif_t[i] && !dif_c[i]));
        end
    endgenerate

    clkgate_ref_ctrl u_ref (
        .clk(clk_ref), .rst(rst), .pg_s(ref_s[1]), .strap_s(ref_s[0]),
        .ref_out(ref_out), .ref_oe(ref_oe), .addr(bus_addr)
    );

    assign pll_ss_code = spread_encode(ss_sel);
endmodule

// File: tb/clkout_gate_ctrl_tb_top.sv
module clkout_gate_ctrl_tb_top;
    localparam int  N          = 6;
    localparam time CLK_PERIOD = 10;
    localparam time REF_PERIOD = 14;

    logic clk_pll = 0, clk_ref = 0, rst = 1;
    logic pll_locked = 0, pwr_good = 0, addr_strap = 0;
    logic [N-1:0] oe_n = '1, reg_oe = '0;
    logic [1:0] ss_sel = 2'b00;
    logic [N-1:0] dif_t, dif_c;
    logic ref_out, ref_oe;
    logic [6:0] bus_addr;
    logic [1:0] pll_ss_code;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk_pll = ~clk_pll;
    always #(REF_PERIOD/2) clk_ref = ~clk_ref;

    clkout_gate_ctrl dut_i (
        .clk_pll(clk_pll), .clk_ref(clk_ref), .rst(rst), .pll_locked(pll_locked),
        .pwr_good(pwr_good), .oe_n(oe_n), .reg_oe(reg_oe), .addr_strap(addr_strap),
        .ss_sel(ss_sel), .dif_t(dif_t), .dif_c(dif_c), .ref_out(ref_out),
        .ref_oe(ref_oe), .bus_addr(bus_addr), .pll_ss_code(pll_ss_code)
    );

    function automatic logic [N-1:0] exp_run();
        return (pwr_good && pll_locked) ? (reg_oe & ~oe_n) : '0;
    endfunction

    function automatic logic [6:0] exp_addr(input logic s);
        return s ? 7'b1101010 : 7'b1101000;
    endfunction

    function automatic logic [1:0] exp_ss(input logic [1:0] s);
        return (s == 2'b11) ? 2'b00 : s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Settles, then watches 8 cycles: running lanes must toggle with c = ~t,
    // parked lanes must keep both legs low.
    task automatic check_lanes(input string req);
        logic [N-1:0] exp, prev, good;
        exp = exp_run();
        repeat (8) @(negedge clk_pll);
        good = '1;
        prev = dif_t;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_pll);
            for (int i = 0; i < N; i++) begin
                if (exp[i]) begin
                    if (dif_t[i] == prev[i] || dif_c[i] != !dif_t[i]) good[i] = 1'b0;
                end else if (dif_t[i] || dif_c[i]) good[i] = 1'b0;
            end
            prev = dif_t;
        end
        for (int i = 0; i < N; i++)
            chk(good[i], req, $sformatf("lane%0d run-ok(expect run=%0d)", i, exp[i]),
                {31'd0, good[i]}, 32'd1);
    endtask

    task automatic check_ref_running(input string req);
        logic prev;
        bit good;
        good = 1;
        repeat (6) @(negedge clk_ref);
        prev = ref_out;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_ref);
            if (ref_out == prev || !ref_oe) good = 0;
            prev = ref_out;
        end
        chk(good, req, "ref toggling with oe", {31'd0, good}, 32'd1);
    endtask

    // Stops lane 0 with a power-down landing on the same edge, then
    // watches every cycle for a truncated or overlapping phase.
    task automatic stop_watch(input int offset);
        bit overlap_free, single_true, comp_handover;
        logic pt, pc;
        overlap_free = 1; single_true = 1; comp_handover = 1;
        repeat (offset) @(posedge clk_pll);
        @(negedge clk_pll);
        oe_n[0]  = 1'b1;
        pwr_good = 1'b0;
        pt = dif_t[0]; pc = dif_c[0];
        for (int k = 0; k < 16; k++) begin
            @(negedge clk_pll);
            if (dif_t[0] && dif_c[0]) overlap_free = 0;
            if (pt && dif_t[0]) single_true = 0;
            if (pc && !dif_t[0]) comp_handover = 0;
            pt = dif_t[0]; pc = dif_c[0];
        end
        chk(overlap_free, "R5", "no overlap during stop", {31'd0, overlap_free}, 32'd1);
        chk(single_true && comp_handover, "R5", "full phases during stop",
            {30'd0, single_true, comp_handover}, 32'd3);
        chk(!dif_t[0] && !dif_c[0], "R6", "parked both low after stop",
            {30'd0, dif_t[0], dif_c[0]}, 32'd0);
        chk(!dif_t[1] && !dif_c[1], "R2", "lane1 parked by power-down",
            {30'd0, dif_t[1], dif_c[1]}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0641));
        repeat (10) @(negedge clk_ref);
        @(negedge clk_pll);
        rst = 0;
        repeat (4) @(negedge clk_pll);

        // Reset state: R7, R9
        chk(dif_t == '0 && dif_c == '0, "R2", "pairs low after reset", {dif_t, dif_c}, 0);
        chk(ref_oe == 1'b0, "R7", "ref hi-z after reset", ref_oe, 0);
        chk(bus_addr == 7'b1101000, "R9", "reset address", bus_addr, 7'b1101000);

        // Lock present, all enabled, power-good still low: R2
        pll_locked = 1; reg_oe = '1; oe_n = '0;
        check_lanes("R2");
        repeat (6) @(negedge clk_ref);
        chk(ref_oe == 1'b0, "R7", "ref hi-z before first power-good", ref_oe, 0);

        // First power-good with strap high: R9, R7, R8, R1
        addr_strap = 1;
        repeat (4) @(negedge clk_ref);
        pwr_good = 1;
        repeat (6) @(negedge clk_ref);
        chk(bus_addr == exp_addr(1), "R9", "strap-high address", bus_addr, exp_addr(1));
        chk(ref_oe == 1'b1, "R7", "ref driven after power-good", ref_oe, 1);
        check_ref_running("R8");
        check_lanes("R1");

        // Lock loss parks everything: R4
        pll_locked = 0;
        check_lanes("R4");
        pll_locked = 1;
        check_lanes("R1");

        // Concurrent power-down and pin release mid-phase: R5, R6, R2
        stop_watch(0);
        pwr_good = 1; oe_n[0] = 0;
        check_lanes("R1");
        stop_watch(1);

        // Power-down keeps ref driven low: R7, R8
        repeat (6) @(negedge clk_ref);
        begin
            bit low_ok;
            low_ok = 1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk_ref);
                if (ref_out || !ref_oe) low_ok = 0;
            end
            chk(low_ok, "R8", "ref low and driven while power down", {31'd0, low_ok}, 1);
            chk(ref_oe == 1'b1, "R7", "ref_oe sticky", ref_oe, 1);
        end

        // Second power-good with strap low: address must not move (R10)
        addr_strap = 0;
        repeat (4) @(negedge clk_ref);
        pwr_good = 1;
        repeat (8) @(negedge clk_ref);
        chk(bus_addr == exp_addr(1), "R10", "address not resampled", bus_addr, exp_addr(1));
        check_ref_running("R8");

        // Directed single-lane gating: R3
        reg_oe = 6'b111110; oe_n = 6'b000000;
        check_lanes("R3");
        reg_oe = 6'b111111; oe_n = 6'b100000;
        check_lanes("R3");

        // Random mixes: R1, R2, R3, R4
        for (int it = 0; it < 30; it++) begin
            reg_oe     = N'($urandom);
            oe_n       = N'($urandom);
            pwr_good   = ($urandom % 5) != 0;
            pll_locked = ($urandom % 5) != 0;
            check_lanes(!pwr_good ? "R2" : (!pll_locked ? "R4" : "R3"));
        end

        // Spread encoding: R11
        for (int s = 0; s < 4; s++) begin
            ss_sel = 2'(s);
            #1;
            chk(pll_ss_code == exp_ss(2'(s)), "R11", $sformatf("spread sel %0d", s),
                pll_ss_code, exp_ss(2'(s)));
        end

        // Reset clears the latched address and the ref enable: R9, R7
        pwr_good = 0; addr_strap = 0;
        @(negedge clk_pll); rst = 1;
        repeat (6) @(negedge clk_ref);
        @(negedge clk_pll); rst = 0;
        repeat (4) @(negedge clk_ref);
        chk(ref_oe == 1'b0, "R7", "ref hi-z after re-reset", ref_oe, 0);
        pwr_good = 1;
        repeat (6) @(negedge clk_ref);
        chk(bus_addr == exp_addr(0), "R9", "strap-low address", bus_addr, exp_addr(0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule